// File: doc/BRIEF.md
# 3x3 Sliding Pixel Window

This block keeps a 3 by 3 window of 8-bit pixels in registers for an image kernel next to it. In a single clock the whole window can move one step up, down, left or right. A full row or column can be written at a given index or at any of the four edges, and a single pixel can be overwritten. One opcode selects among these operations. A shift opcode has a second form that also writes a 3-element vector into the edge the move left empty. All nine pixels leave the block at once on a flat output bus, so the kernel logic reads the window without addressing it.

Commands arrive on a valid/ready interface that carries an opcode, an index, a 3-element vector and one pixel value. The block never applies back-pressure. `cmd_ready` is high whenever reset is released, and a command with `cmd_valid` high is taken and applied on that clock edge. The sender needs no holding logic beyond one command per cycle. Holding or filling the window from line storage, and the arithmetic on the window, are done outside the block.

Top module: `swin_top`

## Requirements
- R1: While `rst_n` is low all nine pixels read 0 and `cmd_ready` is low. After release `cmd_ready` is high.
- R2: With `cmd_valid` low, or with opcode 0 (no operation), the window does not change.
- R3: Opcode 1 (shift up) moves row 1 into row 0 and row 2 into row 1. Row 2 keeps its old contents.
- R4: Opcode 2 (shift down) moves row 1 into row 2 and row 0 into row 1. Row 0 keeps its old contents.
- R5: Opcode 3 (shift left) moves column 1 into column 0 and column 2 into column 1. Opcode 4 (shift right) moves column 1 into column 2 and column 0 into column 1. In both, the vacated column keeps its old contents.
- R6: Opcodes 5, 6, 7 and 8 do the same moves as 1, 2, 3 and 4, and also write the vector into the vacated edge: row 2, row 0, column 2 and column 0 in that order.
- R7: Opcode 9 writes the vector into the row given by `cmd_idx`. Opcode 10 writes it into the column given by `cmd_idx`. All other pixels keep their values.
- R8: Opcodes 11, 12, 13 and 14 write the vector into the top row, bottom row, left column and right column in that order.
- R9: Opcode 15 writes `cmd_pix` into the single pixel whose flat position row*3+col equals `cmd_idx`. The other eight pixels keep their values.
- R10: An index out of range turns the command into a no-op. For opcodes 9 and 10 this is an index of 3 or more, and for opcode 15 it is an index of 9 or more.
- R11: A command taken at a clock edge shows on `win_o` just after that edge and not before it.
- R12: Vector element k is `cmd_vec[8k+7:8k]`. In a row write, element k goes to column k. In a column write, element k goes to row k. Pixel (r,c) is `win_o[8(3r+c)+7 : 8(3r+c)]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present |
| cmd_ready | output | 1 | Command accepted; high whenever out of reset |
| cmd_op | input | 4 | Opcode |
| cmd_idx | input | 4 | Row, column or flat pixel index |
| cmd_vec | input | 24 | Three 8-bit vector elements |
| cmd_pix | input | 8 | Single pixel value |
| win_o | output | 72 | All nine window pixels, registered |

## Verification
The assertions treat every opcode value as meaningful and take no command as pending before reset release. They also expect a command to be seen in the cycle it is valid, since nothing waits on `cmd_ready` while it is high. The stimulus drives all command fields away from the clock edge and holds `cmd_valid` for exactly one cycle per command. It sends out-of-range indices only with opcodes 9, 10 and 15. A directed case also shows that opcode and data left on the bus while `cmd_valid` is low do not change the window.

// File: rtl/swin_pkg.sv
`timescale 1ns/1ps
package swin_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SHU   = 4'd1,
    OP_SHD   = 4'd2,
    OP_SHL   = 4'd3,
    OP_SHR   = 4'd4,
    OP_SHU_F = 4'd5,
    OP_SHD_F = 4'd6,
    OP_SHL_F = 4'd7,
    OP_SHR_F = 4'd8,
    OP_ROW   = 4'd9,
    OP_COL   = 4'd10,
    OP_TOP   = 4'd11,
    OP_BOT   = 4'd12,
    OP_LFT   = 4'd13,
    OP_RGT   = 4'd14,
    OP_PIX   = 4'd15
  } win_op_e;

  // Where one window cell takes its next value from
  typedef enum logic [2:0] {
    SRC_KEEP,   // hold
    SRC_BELOW,  // cell one row down
    SRC_ABOVE,  // cell one row up
    SRC_RIGHT,  // cell one column right
    SRC_LEFT,   // cell one column left
    SRC_VCOL,   // vector element picked by this cell's column
    SRC_VROW,   // vector element picked by this cell's row
    SRC_PIX     // single pixel value
  } cell_src_e;

endpackage

// File: rtl/swin_sel.sv
`timescale 1ns/1ps
module swin_sel
  import swin_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int R    = 0,
  parameter int C    = 0,
  parameter int IW   = 4
) (
  input  logic          en,
  input  logic [3:0]    op,
  input  logic [IW-1:0] idx,
  output cell_src_e     src
);
  localparam bit TOP_R = (R == 0);
  localparam bit BOT_R = (R == ROWS - 1);
  localparam bit LFT_C = (C == 0);
  localparam bit RGT_C = (C == COLS - 1);
  localparam int K     = R * COLS + C;

  int idx_v;
  assign idx_v = int'(idx);

  // Out-of-range indices never match any cell, so the command becomes a no-op
  always_comb begin
    src = SRC_KEEP;
    if (en) begin
      case (win_op_e'(op))
        OP_SHU:   if (!BOT_R) src = SRC_BELOW;
        OP_SHU_F: src = BOT_R ? SRC_VCOL : SRC_BELOW;
        OP_SHD:   if (!TOP_R) src = SRC_ABOVE;
        OP_SHD_F: src = TOP_R ? SRC_VCOL : SRC_ABOVE;
        OP_SHL:   if (!RGT_C) src = SRC_RIGHT;
        OP_SHL_F: src = RGT_C ? SRC_VROW : SRC_RIGHT;
        OP_SHR:   if (!LFT_C) src = SRC_LEFT;
        OP_SHR_F: src = LFT_C ? SRC_VROW : SRC_LEFT;
        OP_ROW:   if (idx_v == R) src = SRC_VCOL;
        OP_COL:   if (idx_v == C) src = SRC_VROW;
        OP_TOP:   if (TOP_R) src = SRC_VCOL;
        OP_BOT:   if (BOT_R) src = SRC_VCOL;
        OP_LFT:   if (LFT_C) src = SRC_VROW;
        OP_RGT:   if (RGT_C) src = SRC_VROW;
        OP_PIX:   if (idx_v == K) src = SRC_PIX;
        default:  src = SRC_KEEP;
      endcase
    end
  end
endmodule

// File: rtl/swin_cell.sv
`timescale 1ns/1ps
module swin_cell
  import swin_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cell_src_e     src,
  input  logic [DW-1:0] d_below,
  input  logic [DW-1:0] d_above,
  input  logic [DW-1:0] d_right,
  input  logic [DW-1:0] d_left,
  input  logic [DW-1:0] d_vcol,
  input  logic [DW-1:0] d_vrow,
  input  logic [DW-1:0] d_pix,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (src)
        SRC_BELOW: q <= d_below;
        SRC_ABOVE: q <= d_above;
        SRC_RIGHT: q <= d_right;
        SRC_LEFT:  q <= d_left;
        SRC_VCOL:  q <= d_vcol;
        SRC_VROW:  q <= d_vrow;
        SRC_PIX:   q <= d_pix;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/swin_top.sv
`timescale 1ns/1ps
module swin_top
  import swin_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int DW   = 8,
  localparam int N   = ROWS * COLS,
  localparam int IW  = $clog2(N),
  localparam int VN  = (ROWS > COLS) ? ROWS : COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [IW-1:0]    cmd_idx,
  input  logic [VN*DW-1:0] cmd_vec,
  input  logic [DW-1:0]    cmd_pix,
  output logic [N*DW-1:0]  win_o
);
  localparam int RW = COLS * DW;
  localparam int WW = N * DW;

  // No back-pressure: every valid command is applied on its edge
  assign cmd_ready = rst_n;

  logic take;
  assign take = cmd_valid & rst_n;

  logic [DW-1:0] cur [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      cell_src_e     src;
      logic [DW-1:0] nb_below, nb_above, nb_right, nb_left;

      if (r < ROWS - 1) begin : g_b
        assign nb_below = cur[r+1][c];
      end else begin : g_b_edge
        assign nb_below = cur[r][c];
      end
      if (r > 0) begin : g_a
        assign nb_above = cur[r-1][c];
      end else begin : g_a_edge
        assign nb_above = cur[r][c];
      end
      if (c < COLS - 1) begin : g_r
        assign nb_right = cur[r][c+1];
      end else begin : g_r_edge
        assign nb_right = cur[r][c];
      end
      if (c > 0) begin : g_l
        assign nb_left = cur[r][c-1];
      end else begin : g_l_edge
        assign nb_left = cur[r][c];
      end

      swin_sel #(.ROWS(ROWS), .COLS(COLS), .R(r), .C(c), .IW(IW)) u_sel (
        .en  (take),
        .op  (cmd_op),
        .idx (cmd_idx),
        .src (src)
      );

      swin_cell #(.DW(DW)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .d_below (nb_below),
        .d_above (nb_above),
        .d_right (nb_right),
        .d_left  (nb_left),
        .d_vcol  (cmd_vec[c*DW +: DW]),
        .d_vrow  (cmd_vec[r*DW +: DW]),
        .d_pix   (cmd_pix),
        .q       (cur[r][c])
      );

      assign win_o[K*DW +: DW] = cur[r][c];

      AST_PIX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PIX && int'(cmd_idx) == K)
        |=> (cur[r][c] == $past(cmd_pix))); // R9
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == OP_NOP) |=> (win_o == $past(win_o))); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SHU)
    |=> (win_o[0 +: WW-RW] == $past(win_o[RW +: WW-RW]))
        && (win_o[WW-RW +: RW] == $past(win_o[WW-RW +: RW]))); // R3

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SHD)
    |=> (win_o[RW +: WW-RW] == $past(win_o[0 +: WW-RW]))
        && (win_o[0 +: RW] == $past(win_o[0 +: RW]))); // R4

  AST_FILL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SHU_F)
    |=> (win_o[WW-RW +: RW] == $past(cmd_vec[0 +: RW]))); // R6

  AST_BAD_ROW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ROW && int'(cmd_idx) >= ROWS)
    |=> (win_o == $past(win_o))); // R10

  AST_BAD_PIX_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PIX && int'(cmd_idx) >= N)
    |=> (win_o == $past(win_o))); // R10

  AST_READY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready); // R1
endmodule

// File: tb/swin_top_tb.sv
`timescale 1ns/1ps
module swin_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [3:0]  cmd_idx = '0;
  logic [23:0] cmd_vec = '0;
  logic [7:0]  cmd_pix = '0;
  logic [71:0] win_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m [3][3];

  always #2.5 clk = ~clk;

  swin_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_vec(cmd_vec), .cmd_pix(cmd_pix),
    .win_o(win_o)
  );

  function automatic logic [23:0] v3(input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] c);
    return {c, b, a};
  endfunction

  function automatic logic [71:0] model_flat();
    logic [71:0] f;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        f[(r*3+c)*8 +: 8] = m[r][c];
    return f;
  endfunction

  task automatic check_win(input string tag);
    logic [71:0] e;
    e = model_flat();
    checks++;
    if (win_o !== e) begin
      failures++;
      $display("FAIL %s window act=%h exp=%h", tag, win_o, e);
    end
  endtask

  // Expected result, written from the requirement text
  task automatic model(input logic [3:0] op, input logic [3:0] idx,
                       input logic [23:0] vec, input logic [7:0] pix);
    logic [7:0] o [3][3];
    logic [7:0] v [3];
    for (int k = 0; k < 3; k++) v[k] = vec[k*8 +: 8];
    o = m;
    case (op)
      4'd1, 4'd5: begin
        for (int c = 0; c < 3; c++) begin
          o[0][c] = m[1][c]; o[1][c] = m[2][c];
          if (op == 4'd5) o[2][c] = v[c];
        end
      end
      4'd2, 4'd6: begin
        for (int c = 0; c < 3; c++) begin
          o[2][c] = m[1][c]; o[1][c] = m[0][c];
          if (op == 4'd6) o[0][c] = v[c];
        end
      end
      4'd3, 4'd7: begin
        for (int r = 0; r < 3; r++) begin
          o[r][0] = m[r][1]; o[r][1] = m[r][2];
          if (op == 4'd7) o[r][2] = v[r];
        end
      end
      4'd4, 4'd8: begin
        for (int r = 0; r < 3; r++) begin
          o[r][2] = m[r][1]; o[r][1] = m[r][0];
          if (op == 4'd8) o[r][0] = v[r];
        end
      end
      4'd9:  if (idx < 3) for (int c = 0; c < 3; c++) o[idx][c] = v[c];
      4'd10: if (idx < 3) for (int r = 0; r < 3; r++) o[r][idx] = v[r];
      4'd11: for (int c = 0; c < 3; c++) o[0][c] = v[c];
      4'd12: for (int c = 0; c < 3; c++) o[2][c] = v[c];
      4'd13: for (int r = 0; r < 3; r++) o[r][0] = v[r];
      4'd14: for (int r = 0; r < 3; r++) o[r][2] = v[r];
      4'd15: if (idx < 9) o[idx/3][idx%3] = pix;
      default: ;
    endcase
    m = o;
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic send(input logic [3:0] op, input logic [3:0] idx,
                      input logic [23:0] vec, input logic [7:0] pix,
                      input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_vec = vec; cmd_pix = pix;
    @(posedge clk); #1;
    model(op, idx, vec, pix);
    check_win(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load_base();
    send(4'd9, 4'd0, v3(8'd1, 8'd2, 8'd3), 8'd0, "R7");
    send(4'd9, 4'd1, v3(8'd4, 8'd5, 8'd6), 8'd0, "R7");
    send(4'd9, 4'd2, v3(8'd7, 8'd8, 8'd9), 8'd0, "R7");
  endtask

  task automatic t_reset();
    for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) m[r][c] = 8'd0;
    checks++;
    if (cmd_ready !== 1'b0) begin
      failures++; $display("FAIL R1 ready in reset act=%b exp=0", cmd_ready);
    end
    check_win("R1");
    @(negedge clk); rst_n = 1'b1; #1;
    checks++;
    if (cmd_ready !== 1'b1) begin
      failures++; $display("FAIL R1 ready after reset act=%b exp=1", cmd_ready);
    end
    @(negedge clk);
  endtask

  task automatic t_idle();
    load_base();
    cmd_valid = 1'b0; cmd_op = 4'd1; cmd_vec = 24'hAABBCC; cmd_idx = 4'd0;
    repeat (2) @(posedge clk);
    #1 check_win("R2 valid low");
    @(negedge clk);
    send(4'd0, 4'd1, 24'h112233, 8'h44, "R2 nop");
  endtask

  task automatic t_shift_rows();
    load_base();
    send(4'd1, 4'd0, 24'h0, 8'd0, "R3");
    send(4'd1, 4'd0, 24'h0, 8'd0, "R3 twice");
    load_base();
    send(4'd2, 4'd0, 24'h0, 8'd0, "R4");
    send(4'd2, 4'd0, 24'h0, 8'd0, "R4 twice");
  endtask

  task automatic t_shift_cols();
    load_base();
    send(4'd3, 4'd0, 24'h0, 8'd0, "R5 left");
    load_base();
    send(4'd4, 4'd0, 24'h0, 8'd0, "R5 right");
  endtask

  task automatic t_fill();
    load_base();
    send(4'd5, 4'd0, v3(8'hA0, 8'hA1, 8'hA2), 8'd0, "R6 up");
    send(4'd6, 4'd0, v3(8'hB0, 8'hB1, 8'hB2), 8'd0, "R6 down");
    send(4'd7, 4'd0, v3(8'hC0, 8'hC1, 8'hC2), 8'd0, "R6 left");
    send(4'd8, 4'd0, v3(8'hD0, 8'hD1, 8'hD2), 8'd0, "R6 right");
  endtask

  task automatic t_row_col();
    load_base();
    send(4'd9,  4'd1, v3(8'd50, 8'd50, 8'd50), 8'd0, "R7 row1");
    send(4'd10, 4'd0, v3(8'h10, 8'h20, 8'h30), 8'd0, "R12 col0");
    send(4'd10, 4'd2, v3(8'h31, 8'h32, 8'h33), 8'd0, "R7 col2");
  endtask

  task automatic t_edges();
    load_base();
    send(4'd11, 4'd0, v3(8'hE1, 8'hE2, 8'hE3), 8'd0, "R8 top");
    send(4'd12, 4'd0, v3(8'hF1, 8'hF2, 8'hF3), 8'd0, "R8 bottom");
    send(4'd13, 4'd0, v3(8'h61, 8'h62, 8'h63), 8'd0, "R8 left");
    send(4'd14, 4'd0, v3(8'h71, 8'h72, 8'h73), 8'd0, "R8 right");
  endtask

  task automatic t_pixel();
    load_base();
    send(4'd15, 4'd0, 24'hFFFFFF, 8'h5A, "R9 first");
    send(4'd15, 4'd5, 24'h0, 8'hC3, "R9 mid");
    send(4'd15, 4'd8, 24'h0, 8'h99, "R9 last");
  endtask

  task automatic t_bad_idx();
    load_base();
    send(4'd9,  4'd3,  24'h777777, 8'd0, "R10 row");
    send(4'd10, 4'd5,  24'h777777, 8'd0, "R10 col");
    send(4'd15, 4'd9,  24'h0, 8'hEE, "R10 pix9");
    send(4'd15, 4'd15, 24'h0, 8'hEE, "R10 pix15");
  endtask

  task automatic t_latency();
    load_base();
    cmd_valid = 1'b1; cmd_op = 4'd15; cmd_idx = 4'd4; cmd_pix = 8'h3C;
    #1 check_win("R11 before edge");
    @(posedge clk); #1;
    model(4'd15, 4'd4, 24'h0, 8'h3C);
    check_win("R11 after edge");
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_idle();
    t_shift_rows();
    t_shift_cols();
    t_fill();
    t_row_col();
    t_edges();
    t_pixel();
    t_bad_idx();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule